// File: doc/BRIEF.md
# Coolant Flow Setting Selector

This block turns a forecast of the hottest on-die temperature into one of five discrete pump flow settings. A new forecast arrives once per sampling interval, which is marked by a one-cycle tick. On that tick the block compares the forecast against four programmable boundary temperatures. Each boundary separates two adjacent flow settings. The output is the lowest setting whose boundaries the forecast has not reached. The boundaries are placed so that the chosen setting keeps the die below its 80 °C target.

A hotter forecast raises the setting on the same tick, and it may skip several settings at once. A cooler forecast lowers the setting by only one step per tick. That step happens only when the forecast lies a fixed hysteresis margin below the boundary between the current setting and the one beneath it. This stops the pump from toggling when the forecast dithers around a boundary.

Software rewrites the boundaries through a small write port. A write that would break the strictly increasing order of the boundaries is dropped, and it sets a sticky error flag. Temperatures are unsigned values in steps of 0.25 °C.

Top module: `flow_rate_selector`

## Requirements
- R1: During and after reset the setting output is 4 (the highest) and the error flag is 0. The boundaries are restored to 240, 264, 288 and 312 (index 0 to 3), which is BND_BASE + index × BND_STEP.
- R2: On a tick, the required level is the number of boundaries that are less than or equal to temp_i. If that level is above the current setting, the output takes that level at the next clock edge, skipping levels if needed.
- R3: Without a tick the setting output does not change, whatever temp_i does.
- R4: On a tick where the required level is below the current setting s, the output drops to s−1 when temp_i + HYST ≤ boundary[s−1]. HYST defaults to 8, which is 2 °C.
- R5: The setting never decreases by more than one per tick, even when temp_i lies far below several boundaries.
- R6: On a tick where the required level is below the current setting s but temp_i + HYST > boundary[s−1], the output keeps s.
- R7: A write of wr_data_i to boundary wr_addr_i is accepted only when the value is strictly greater than boundary[wr_addr_i−1] (if that entry exists) and strictly less than boundary[wr_addr_i+1] (if that entry exists). Any other write leaves every boundary unchanged and sets cfg_err_o at the next edge.
- R8: Once set, cfg_err_o stays at 1 until reset, including through later accepted writes.
- R9: An accepted write is used by every tick that comes after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle sampling strobe; a decision is made when it is high |
| temp_i | input | TEMP_W | Forecast peak temperature, unsigned, 0.25 °C per LSB |
| wr_en_i | input | 1 | Boundary write strobe |
| wr_addr_i | input | ADDR_W | Boundary index to write (0 is the lowest) |
| wr_data_i | input | TEMP_W | New boundary temperature |
| setting_o | output | SET_W | Selected flow setting, 0 to N_SET−1 |
| cfg_err_o | output | 1 | Sticky flag for a rejected boundary write |

## Verification
The bench builds the block with its default parameters: 10-bit temperatures, five settings, an 8-LSB margin, and boundaries spaced 24 LSB apart starting at 240. With these values every boundary and every margin edge lies a few LSB apart. Short forecast sequences can therefore hit the exact LSB where a step down is first allowed, and the last LSB where it is still held back. The spacing also makes a rejected write visible: the rejected value would move the required level for a chosen forecast, so a tick after the write shows whether it was applied. A second reset after reprogramming shows that the default boundaries come back.

// File: rtl/flow_sel_pkg.sv
`timescale 1ns/1ps
package flow_sel_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Reset value of boundary k: evenly spaced from base.
  function automatic int unsigned bnd_default(int unsigned base, int unsigned step,
                                              int unsigned k);
    return base + k * step;
  endfunction

endpackage

// File: rtl/flow_bnd_table.sv
`timescale 1ns/1ps
module flow_bnd_table #(
  parameter int unsigned TEMP_W   = 10,
  parameter int unsigned N_BND    = 4,
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned BND_BASE = 240,
  parameter int unsigned BND_STEP = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [TEMP_W-1:0]              wr_data_i,
  output logic [N_BND-1:0][TEMP_W-1:0]   bnd_o,
  output logic                           err_o
);

  logic [TEMP_W-1:0] bnd_q [N_BND];
  logic [N_BND-1:0]  sel;
  logic [N_BND-1:0]  lo_ok;
  logic [N_BND-1:0]  hi_ok;
  logic              wr_ok;
  logic              err_q;

  for (genvar k = 0; k < N_BND; k++) begin : g_ent
    assign sel[k] = (wr_addr_i == ADDR_W'(k));

    if (k == 0) begin : g_lo_none
      assign lo_ok[k] = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok[k] = wr_data_i > bnd_q[k-1];
    end

    if (k == N_BND - 1) begin : g_hi_none
      assign hi_ok[k] = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok[k] = wr_data_i < bnd_q[k+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bnd_q[k] <= TEMP_W'(flow_sel_pkg::bnd_default(BND_BASE, BND_STEP, k));
      end else if (wr_ok && sel[k]) begin
        bnd_q[k] <= wr_data_i;
      end
    end

    assign bnd_o[k] = bnd_q[k];
  end

  // Out-of-range address selects nothing and is rejected.
  assign wr_ok = wr_en_i && |(sel & lo_ok & hi_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (wr_en_i && !wr_ok) begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  for (genvar k = 0; k + 1 < N_BND; k++) begin : g_ord_chk
    a_r7_order_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bnd_o[k] < bnd_o[k+1])
      else $error("R7: boundary order broken at %0d", k);
  end

  a_r7_reject_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_ok) |=> (bnd_o == $past(bnd_o) && err_o))
    else $error("R7: rejected write changed table or missed flag");

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o)
    else $error("R8: error flag cleared without reset");

endmodule

// File: rtl/flow_level_cmp.sv
`timescale 1ns/1ps
module flow_level_cmp #(
  parameter int unsigned TEMP_W = 10,
  parameter int unsigned N_BND  = 4,
  parameter int unsigned SET_W  = 3,
  parameter int unsigned HYST   = 8
) (
  input  logic [TEMP_W-1:0]              temp_i,
  input  logic [N_BND-1:0][TEMP_W-1:0]   bnd_i,
  output logic [SET_W-1:0]               req_o,
  output logic [N_BND-1:0]               clear_o
);

  localparam int unsigned EXT_W = TEMP_W + 1;

  logic [N_BND-1:0] ge;

  for (genvar k = 0; k < N_BND; k++) begin : g_cmp
    assign ge[k]      = temp_i >= bnd_i[k];
    // Margin test done one bit wider so temp + HYST cannot wrap.
    assign clear_o[k] = (EXT_W'(temp_i) + EXT_W'(HYST)) <= EXT_W'(bnd_i[k]);
  end

  always_comb begin
    req_o = '0;
    for (int k = 0; k < N_BND; k++) begin
      req_o = req_o + SET_W'(ge[k]);
    end
  end

endmodule

// File: rtl/flow_step_ctrl.sv
`timescale 1ns/1ps
module flow_step_ctrl
  import flow_sel_pkg::*;
#(
  parameter int unsigned N_SET  = 5,
  parameter int unsigned N_BND  = 4,
  parameter int unsigned SET_W  = 3,
  parameter int unsigned BND_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [SET_W-1:0]  req_i,
  input  logic [N_BND-1:0]  clear_i,
  output logic [SET_W-1:0]  set_o
);

  localparam logic [SET_W-1:0] TOP_SET = SET_W'(N_SET - 1);

  logic [SET_W-1:0]  cur_q;
  logic [SET_W-1:0]  cur_d;
  logic [BND_AW-1:0] low_idx;
  logic              down_ok;
  step_e             step;

  always_comb begin
    low_idx = BND_AW'(cur_q - SET_W'(1));
    down_ok = (cur_q != '0) && clear_i[low_idx];
    step    = STEP_HOLD;
    if (tick_i) begin
      if (req_i > cur_q)                 step = STEP_UP;
      else if (req_i < cur_q && down_ok) step = STEP_DOWN;
    end
    unique case (step)
      STEP_UP:   cur_d = req_i;
      STEP_DOWN: cur_d = cur_q - SET_W'(1);
      default:   cur_d = cur_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= TOP_SET;
    else         cur_q <= cur_d;
  end

  assign set_o = cur_q;

  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o <= TOP_SET)
    else $error("R1: setting out of range");

  a_r2_rise_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && req_i > set_o) |=> (set_o == $past(req_i)))
    else $error("R2: upward step delayed");

  a_r3_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(set_o))
    else $error("R3: setting moved without tick");

  a_r5_one_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o < $past(set_o)) |-> (set_o == SET_W'($past(set_o) - SET_W'(1))))
    else $error("R5: dropped more than one step");

  a_r6_hold_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && req_i < set_o && !clear_i[low_idx]) |=> $stable(set_o))
    else $error("R6: stepped down inside margin");

endmodule

// File: rtl/flow_rate_selector.sv
`timescale 1ns/1ps
module flow_rate_selector #(
  parameter int unsigned TEMP_W   = 10,
  parameter int unsigned N_SET    = 5,
  parameter int unsigned HYST     = 8,
  parameter int unsigned BND_BASE = 240,
  parameter int unsigned BND_STEP = 24,
  localparam int unsigned N_BND   = N_SET - 1,
  localparam int unsigned SET_W   = $clog2(N_SET),
  localparam int unsigned ADDR_W  = (N_BND > 1) ? $clog2(N_BND) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [TEMP_W-1:0] wr_data_i,
  output logic [SET_W-1:0]  setting_o,
  output logic              cfg_err_o
);

  logic [N_BND-1:0][TEMP_W-1:0] bnd;
  logic [SET_W-1:0]             req;
  logic [N_BND-1:0]             clear;

  flow_bnd_table #(
    .TEMP_W  (TEMP_W),
    .N_BND   (N_BND),
    .ADDR_W  (ADDR_W),
    .BND_BASE(BND_BASE),
    .BND_STEP(BND_STEP)
  ) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .bnd_o    (bnd),
    .err_o    (cfg_err_o)
  );

  flow_level_cmp #(
    .TEMP_W(TEMP_W),
    .N_BND (N_BND),
    .SET_W (SET_W),
    .HYST  (HYST)
  ) u_cmp (
    .temp_i (temp_i),
    .bnd_i  (bnd),
    .req_o  (req),
    .clear_o(clear)
  );

  flow_step_ctrl #(
    .N_SET (N_SET),
    .N_BND (N_BND),
    .SET_W (SET_W),
    .BND_AW(ADDR_W)
  ) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .req_i  (req),
    .clear_i(clear),
    .set_o  (setting_o)
  );

endmodule

// File: tb/flow_rate_selector_bench.sv
`timescale 1ns/1ps
module flow_rate_selector_bench;

  logic       clk_i     = 1'b0;
  logic       rst_ni    = 1'b0;
  logic       tick_i    = 1'b0;
  logic [9:0] temp_i    = '0;
  logic       wr_en_i   = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [9:0] wr_data_i = '0;
  logic [2:0] setting_o;
  logic       cfg_err_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  item_ev;

  always #10 clk_i = ~clk_i;

  flow_rate_selector #(
    .TEMP_W(10), .N_SET(5), .HYST(8), .BND_BASE(240), .BND_STEP(24)
  ) u_flow_rate_selector (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .temp_i(temp_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .setting_o(setting_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: compare queued expectations once the driver signals them.
  initial begin
    item_t it;
    forever begin
      @(item_ev);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, int'(setting_o), int'(it.exp));
      end
    end
  end

  task automatic tick_step(input logic [9:0] t, input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk_i);
    temp_i = t;
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    ->item_ev;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk_i);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R1 setting in reset", int'(setting_o), 4);
    check("R1 err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 setting after reset", int'(setting_o), 4);

    // R4 R5: far below every boundary, one step per tick
    tick_step(10'd100, 3'd3, "R5 fall 4->3");
    tick_step(10'd100, 3'd2, "R5 fall 3->2");
    tick_step(10'd100, 3'd1, "R4 fall 2->1");
    tick_step(10'd100, 3'd0, "R4 fall 1->0");

    // R2: rising, including a skip of two levels
    tick_step(10'd250, 3'd1, "R2 rise to 1");
    tick_step(10'd300, 3'd3, "R2 jump 1->3");
    tick_step(10'd312, 3'd4, "R2 at boundary 312");

    // R6 / R4 dithering around boundary 312
    tick_step(10'd310, 3'd4, "R6 hold 310");
    tick_step(10'd305, 3'd4, "R6 hold 305 edge");
    tick_step(10'd304, 3'd3, "R4 margin exact 304");
    tick_step(10'd315, 3'd4, "R2 back up 315");
    tick_step(10'd304, 3'd3, "R4 down again 304");
    tick_step(10'd290, 3'd3, "R6 hold 290");
    tick_step(10'd281, 3'd3, "R6 hold 281 edge");
    tick_step(10'd280, 3'd2, "R4 margin exact 280");

    // R3: no tick, input swings
    @(negedge clk_i);
    temp_i = 10'd0;
    repeat (3) @(negedge clk_i);
    check("R3 hold low temp no tick", int'(setting_o), 2);
    temp_i = 10'd1000;
    repeat (3) @(negedge clk_i);
    check("R3 hold high temp no tick", int'(setting_o), 2);

    // R9: boundary 0 moved to 200
    wr(2'd0, 10'd200);
    check("R7 valid write no err", int'(cfg_err_o), 0);
    tick_step(10'd205, 3'd1, "R9 fall to 1");
    tick_step(10'd205, 3'd1, "R9 hold level 1");
    tick_step(10'd195, 3'd1, "R6 hold 195");
    tick_step(10'd192, 3'd0, "R4 margin 192 new bnd");
    tick_step(10'd200, 3'd1, "R9 new bnd 200 used");

    // R7: out-of-order write rejected
    wr(2'd2, 10'd260);
    check("R7 bad write sets err", int'(cfg_err_o), 1);
    tick_step(10'd270, 3'd2, "R7 bad write ignored");
    wr(2'd1, 10'd200);
    check("R8 err stays after bad write", int'(cfg_err_o), 1);
    wr(2'd3, 10'd400);
    check("R8 err stays after good write", int'(cfg_err_o), 1);
    tick_step(10'd350, 3'd3, "R9 bnd3 400 used");
    tick_step(10'd198, 3'd2, "R7 bnd1 still 264");

    // R1: second reset restores defaults
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 err cleared by reset", int'(cfg_err_o), 0);
    check("R1 setting back to 4", int'(setting_o), 4);
    rst_ni = 1'b1;
    tick_step(10'd314, 3'd4, "R1 hold 314");
    tick_step(10'd305, 3'd4, "R1 bnd3 back to 312");
    tick_step(10'd240, 3'd3, "R1 step 240");

    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule